// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a target on a two-wire SMBus that owns a bank of 22 byte-wide configuration registers, numbered 0 to 21. It exposes the whole bank in parallel on a wide output port, so the surrounding logic can use any field directly. The bus lines arrive as open-drain levels. Both are resynchronised to the system clock. The only pin the target ever drives is an enable that pulls SDA low.

A host changes the bank with a block write. That transfer carries the target's write address, then a starting index, then a byte count, then that many data bytes, which fill consecutive registers. To read, the host first performs a write-address phase that carries only the index. It then issues a repeated start with the read address. The target answers with the byte-count register value first and then streams registers from the index upward until the host refuses a byte. The host therefore learns the read length from a register it can program, and it does not choose that length itself.

Top module: `smb_regbank_target`

## Requirements
- R1: After reset, register 8 holds 9, register 6 holds 0x81, register 7 holds 0x01, every other register holds 0x00, and SDA is released.
- R2: The target acknowledges the address bytes 0xD2 (write) and 0xD3 (read). It does not acknowledge any other address byte, and it ignores the rest of that transfer until the next start or stop.
- R3: In a write transfer, the target acknowledges each received byte (address, index, count and every data byte) by holding SDA low during the ninth clock.
- R4: Bytes are sent MSB first. In a write, the first byte after the address is the starting index N and the second is the count X. The next X bytes land in registers N to N+X-1, and any further bytes are acknowledged but discarded.
- R5: A read consists of a write-address phase with the index, a repeated start, and then 0xD3. The target first sends the value of register 8, then registers N, N+1, and so on.
- R6: While the host acknowledges, the target keeps sending. After a not-acknowledge, the target leaves SDA released until the next start or stop.
- R7: Registers 6 and 7 are read-only. Writes to them are acknowledged and have no effect.
- R8: Register 8 is writable, and its value is the count byte that a read returns first.
- R9: A write to an index above 21 is acknowledged and dropped. A read from an index above 21 returns 0x00.
- R10: A stop or start that arrives inside a byte abandons that byte. Nothing is written from it, bytes completed earlier stay written, and the target then waits for a new transfer (after a stop) or a new address byte (after a start).
- R11: The target changes its SDA drive only after it has detected a falling SCL edge, or on a start or stop. It never changes the drive while SCL is high.
- R12: `regs_o[8*i+7:8*i]` always shows register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample both bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 176 | All 22 registers, register i at bits 8i+7..8i |

## Verification
Two things happen on the same detected SCL fall at the end of a data byte: the register write is committed and the acknowledge drive begins. The bench provokes this by ending a transfer with a stop immediately after that acknowledge clock, and by cutting the next byte short with either a stop or a repeated start. It then judges from the parallel port that the committed byte survived and the partial byte left nothing behind. A second same-edge case occurs at the end of the read-address acknowledge, where the acknowledge is released and the first bit of the count byte is launched together. This is judged by sampling each transmitted bit twice while SCL is high, and the two samples must agree.

// File: rtl/smb_regbank_pkg.sv
package smb_regbank_pkg;
  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  // Transfer phases of the protocol engine
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_TX,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/smb_line_cond.sv
// Resynchronises SCL/SDA and derives edge and bus-condition strobes.
module smb_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_p <= scl_q[SYNC_STAGES-1];
      sda_p <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_q[SYNC_STAGES-1];
  assign sda_s     = sda_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_regfile.sv
// Register bank: writable flops plus constant read-only entries.
module smb_regfile
  import smb_regbank_pkg::*;
#(
  parameter int    NUM_REGS = 22,
  parameter int    CNT_IDX  = 8,
  parameter byte_t CNT_RST  = 8'd9,
  parameter int    ID_IDX   = 6,
  parameter byte_t ID_VAL   = 8'h81,
  parameter int    VEND_IDX = 7,
  parameter byte_t VEND_VAL = 8'h01
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  byte_t                      wr_idx,
  input  byte_t                      wr_data,
  input  byte_t                      rd_idx,
  output byte_t                      rd_data,
  output byte_t                      cnt_data,
  output logic [NUM_REGS*BYTE_W-1:0] flat_o
);
  localparam int FLAT_W = NUM_REGS * BYTE_W;

  logic [FLAT_W-1:0] flat;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == ID_IDX) begin : g_id
      assign flat[g*BYTE_W +: BYTE_W] = ID_VAL;
    end else if (g == VEND_IDX) begin : g_vend
      assign flat[g*BYTE_W +: BYTE_W] = VEND_VAL;
    end else begin : g_rw
      localparam byte_t RST_VAL = (g == CNT_IDX) ? CNT_RST : 8'h00;
      byte_t q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= RST_VAL;
        end else if (wr_en && (wr_idx == BYTE_W'(g))) begin
          q <= wr_data;
        end
      end
      assign flat[g*BYTE_W +: BYTE_W] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == BYTE_W'(i)) rd_data = flat[i*BYTE_W +: BYTE_W];
    end
  end

  assign cnt_data = flat[CNT_IDX*BYTE_W +: BYTE_W];
  assign flat_o   = flat;
endmodule

// File: rtl/smb_proto_fsm.sv
// Bit/byte engine for indexed block write and indexed block read.
module smb_proto_fsm
  import smb_regbank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   sda_s,
  input  logic   scl_rise,
  input  logic   scl_fall,
  input  logic   start_det,
  input  logic   stop_det,
  input  byte_t  rd_data,
  input  byte_t  cnt_data,
  output byte_t  rd_idx,
  output logic   wr_en,
  output byte_t  wr_idx,
  output byte_t  wr_data,
  output logic   sda_oe,
  output phase_e phase_o
);
  localparam int    BCW      = $clog2(BYTE_W + 1);
  localparam byte_t ADDR_WR  = {DEV_ADDR, 1'b0};
  localparam byte_t ADDR_RD  = {DEV_ADDR, 1'b1};

  phase_e                phase;
  logic [BCW-1:0]        bitcnt;
  byte_t                 rx_sh;
  logic [BYTE_W-2:0]     tx_rest;
  logic                  ack_slot;
  logic                  host_nack;
  logic                  tx_pending;
  byte_t                 ptr;
  byte_t                 remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      bitcnt     <= '0;
      rx_sh      <= '0;
      tx_rest    <= '0;
      ack_slot   <= 1'b0;
      host_nack  <= 1'b0;
      tx_pending <= 1'b0;
      ptr        <= '0;
      remain     <= '0;
      sda_oe     <= 1'b0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det || stop_det) begin
        // Any bus condition drops a partial byte
        phase      <= start_det ? PH_ADDR : PH_IDLE;
        bitcnt     <= '0;
        ack_slot   <= 1'b0;
        tx_pending <= 1'b0;
        sda_oe     <= 1'b0;
      end else begin
        case (phase)
          PH_IDLE, PH_SKIP: begin
            sda_oe <= 1'b0;
          end
          PH_TX: begin
            if (scl_rise) begin
              if (ack_slot) host_nack <= sda_s;
              else          bitcnt    <= bitcnt + 1'b1;
            end
            if (scl_fall) begin
              if (ack_slot) begin
                ack_slot <= 1'b0;
                if (host_nack) begin
                  phase  <= PH_SKIP;
                  sda_oe <= 1'b0;
                end else begin
                  tx_rest <= rd_data[BYTE_W-2:0];
                  sda_oe  <= ~rd_data[BYTE_W-1];
                  ptr     <= ptr + 1'b1;
                  bitcnt  <= '0;
                end
              end else if (bitcnt == BCW'(BYTE_W)) begin
                sda_oe   <= 1'b0;
                ack_slot <= 1'b1;
              end else begin
                sda_oe  <= ~tx_rest[BYTE_W-2];
                tx_rest <= {tx_rest[BYTE_W-3:0], 1'b0};
              end
            end
          end
          default: begin
            if (scl_rise && !ack_slot) begin
              rx_sh  <= {rx_sh[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end
            if (scl_fall) begin
              if (ack_slot) begin
                ack_slot <= 1'b0;
                bitcnt   <= '0;
                if (tx_pending) begin
                  tx_pending <= 1'b0;
                  phase      <= PH_TX;
                  tx_rest    <= cnt_data[BYTE_W-2:0];
                  sda_oe     <= ~cnt_data[BYTE_W-1];
                end else begin
                  sda_oe <= 1'b0;
                end
              end else if (bitcnt == BCW'(BYTE_W)) begin
                ack_slot <= 1'b1;
                case (phase)
                  PH_ADDR: begin
                    if (rx_sh == ADDR_WR) begin
                      sda_oe <= 1'b1;
                      phase  <= PH_INDEX;
                    end else if (rx_sh == ADDR_RD) begin
                      sda_oe     <= 1'b1;
                      tx_pending <= 1'b1;
                    end else begin
                      sda_oe   <= 1'b0;
                      ack_slot <= 1'b0;
                      phase    <= PH_SKIP;
                    end
                  end
                  PH_INDEX: begin
                    ptr    <= rx_sh;
                    sda_oe <= 1'b1;
                    phase  <= PH_COUNT;
                  end
                  PH_COUNT: begin
                    remain <= rx_sh;
                    sda_oe <= 1'b1;
                    phase  <= PH_WDATA;
                  end
                  default: begin
                    sda_oe <= 1'b1;
                    if (remain != '0) begin
                      wr_en   <= 1'b1;
                      wr_idx  <= ptr;
                      wr_data <= rx_sh;
                      ptr     <= ptr + 1'b1;
                      remain  <= remain - 1'b1;
                    end
                  end
                endcase
              end
            end
          end
        endcase
      end
    end
  end

  assign rd_idx  = ptr;
  assign phase_o = phase;
endmodule

// File: rtl/smb_regbank_target.sv
module smb_regbank_target
  import smb_regbank_pkg::*;
#(
  parameter int         NUM_REGS    = 22,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2,
  parameter int         CNT_IDX     = 8,
  parameter byte_t      CNT_RST     = 8'd9,
  parameter int         ID_IDX      = 6,
  parameter byte_t      ID_VAL      = 8'h81,
  parameter int         VEND_IDX    = 7,
  parameter byte_t      VEND_VAL    = 8'h01
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic   sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic   wr_en;
  byte_t  wr_idx, wr_data, rd_idx, rd_data, cnt_data;
  phase_e phase;

  smb_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_proto_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .cnt_data  (cnt_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe_o),
    .phase_o   (phase)
  );

  smb_regfile #(
    .NUM_REGS (NUM_REGS),
    .CNT_IDX  (CNT_IDX),
    .CNT_RST  (CNT_RST),
    .ID_IDX   (ID_IDX),
    .ID_VAL   (ID_VAL),
    .VEND_IDX (VEND_IDX),
    .VEND_VAL (VEND_VAL)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .cnt_data (cnt_data),
    .flat_o   (regs_o)
  );
endmodule

// File: rtl/smb_regbank_checker.sv
module smb_regbank_checker
  import smb_regbank_pkg::*;
#(
  parameter int NUM_REGS = 22,
  parameter int ID_IDX   = 6,
  parameter int VEND_IDX = 7
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       scl_fall,
  input logic                       start_det,
  input logic                       stop_det,
  input logic                       sda_oe,
  input phase_e                     phase,
  input logic                       wr_en,
  input byte_t                      wr_idx,
  input logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  // R11: drive changes only follow an SCL fall or a bus condition
  a_r11_sda_moves_on_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  // R10: a stop always returns the engine to idle
  a_r10_stop_goes_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (phase == PH_IDLE));

  // R2: an ignored transfer never drives SDA
  a_r2_skip_keeps_sda_released: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> !sda_oe);

  // R4: register writes come only from the data phase, one cycle each
  a_r4_write_from_data_phase: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(phase) == PH_WDATA));

  a_r4_write_pulse_single: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R7: writes aimed at read-only entries leave the bank unchanged
  a_r7_ro_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ((wr_idx == BYTE_W'(ID_IDX)) || (wr_idx == BYTE_W'(VEND_IDX))))
    |=> $stable(regs_o));

  // R9: writes above the top index leave the bank unchanged
  a_r9_oob_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx >= BYTE_W'(NUM_REGS))) |=> $stable(regs_o));
endmodule

bind smb_regbank_target smb_regbank_checker #(
  .NUM_REGS (NUM_REGS),
  .ID_IDX   (ID_IDX),
  .VEND_IDX (VEND_IDX)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe_o),
  .phase     (phase),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .regs_o    (regs_o)
);

// File: tb/tb_smb_regbank_target.sv
module tb_smb_regbank_target;
  localparam int NREG = 22;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NREG*8-1:0] regs;

  int n_tot  = 0;
  int n_fail = 0;
  logic tx_glitch = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = host_sda & ~sda_oe;

  smb_regbank_target dut (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (host_scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  function automatic logic [7:0] rg(input int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; host_scl = 1'b1; tick(Q);
    host_sda = 1'b0; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    host_sda = 1'b1; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_sda = 1'b0; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    host_sda = b; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    host_sda = 1'b1; tick(Q);
    host_scl = 1'b1; tick(Q/2);
    acked = ~sda_line;
    tick(Q/2);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s0;
    for (int i = 7; i >= 0; i--) begin
      host_sda = 1'b1; tick(Q);
      host_scl = 1'b1; tick(Q/2);
      s0 = sda_line;
      tick(Q/2);
      if (sda_line !== s0) tx_glitch = 1'b1;
      b[i] = s0;
      host_scl = 1'b0;
    end
    host_sda = ~give_ack; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_scl = 1'b0; tick(Q);
    host_sda = 1'b1;
  endtask

  task automatic wr_hdr(input logic [7:0] idx, input logic [7:0] cnt, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(idx, a1);
    send_byte(cnt, a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_hdr(input logic [7:0] idx, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0);
    send_byte(idx, a1);
    bus_rstart();
    send_byte(8'hD3, a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic t_reset();
    chk("R1", "sda released", sda_oe, 0);
    chk("R1", "count reg", rg(8), 8'h09);
    chk("R1", "id reg", rg(6), 8'h81);
    chk("R1", "vendor reg", rg(7), 8'h01);
    chk("R12", "reg0 slice", rg(0), 8'h00);
    chk("R1", "reg21", rg(21), 8'h00);
  endtask

  task automatic t_write_block();
    logic ok, a, all;
    wr_hdr(8'd1, 8'd3, ok);
    chk("R3", "header acks", ok, 1);
    all = 1'b1;
    send_byte(8'hA1, a); all &= a;
    send_byte(8'hB2, a); all &= a;
    send_byte(8'hC3, a); all &= a;
    bus_stop();
    chk("R3", "data acks", all, 1);
    chk("R4", "reg1", rg(1), 8'hA1);
    chk("R4", "reg2", rg(2), 8'hB2);
    chk("R12", "reg3", rg(3), 8'hC3);
    chk("R4", "reg0 untouched", rg(0), 8'h00);
    chk("R4", "reg4 untouched", rg(4), 8'h00);
  endtask

  task automatic t_extra_bytes();
    logic ok, a1, a2;
    wr_hdr(8'd10, 8'd1, ok);
    send_byte(8'h55, a1);
    send_byte(8'h66, a2);
    bus_stop();
    chk("R4", "extra byte acked", ok & a1 & a2, 1);
    chk("R4", "reg10", rg(10), 8'h55);
    chk("R4", "reg11 beyond count", rg(11), 8'h00);
  endtask

  task automatic t_bad_addr();
    logic a0, a1, a2, a3;
    logic [NREG*8-1:0] snap;
    snap = regs;
    bus_start();
    send_byte(8'hA0, a0);
    send_byte(8'h00, a1);
    send_byte(8'h01, a2);
    send_byte(8'h5A, a3);
    bus_stop();
    chk("R2", "foreign addr ack", a0, 0);
    chk("R2", "later bytes ack", a1 | a2 | a3, 0);
    chk("R2", "bank unchanged", (regs == snap), 1);
  endtask

  task automatic t_read_block();
    logic ok;
    logic [7:0] b;
    tx_glitch = 1'b0;
    rd_hdr(8'd1, ok);
    chk("R5", "read header acks", ok, 1);
    recv_byte(1'b1, b); chk("R5", "count byte", b, 8'h09);
    recv_byte(1'b1, b); chk("R5", "data 1", b, 8'hA1);
    recv_byte(1'b1, b); chk("R5", "data 2", b, 8'hB2);
    recv_byte(1'b0, b); chk("R6", "data 3", b, 8'hC3);
    chk("R6", "released after nack", sda_oe, 0);
    bus_stop();
    chk("R11", "bits steady while SCL high", tx_glitch, 0);
  endtask

  task automatic t_ro_regs();
    logic ok, a1, a2;
    logic [7:0] b;
    wr_hdr(8'd6, 8'd2, ok);
    send_byte(8'h00, a1);
    send_byte(8'hFF, a2);
    bus_stop();
    chk("R7", "ro writes acked", ok & a1 & a2, 1);
    chk("R7", "id kept", rg(6), 8'h81);
    chk("R7", "vendor kept", rg(7), 8'h01);
    rd_hdr(8'd6, ok);
    recv_byte(1'b1, b);
    recv_byte(1'b1, b); chk("R7", "id over bus", b, 8'h81);
    recv_byte(1'b0, b); chk("R7", "vendor over bus", b, 8'h01);
    bus_stop();
  endtask

  task automatic t_count_reg();
    logic ok, a;
    logic [7:0] b;
    wr_hdr(8'd8, 8'd1, ok);
    send_byte(8'h03, a);
    bus_stop();
    chk("R8", "count reg written", rg(8), 8'h03);
    rd_hdr(8'd2, ok);
    recv_byte(1'b1, b); chk("R8", "count byte follows reg", b, 8'h03);
    recv_byte(1'b0, b); chk("R5", "read from index 2", b, 8'hB2);
    bus_stop();
  endtask

  task automatic t_oob();
    logic ok, a1, a2, a3;
    logic [7:0] b;
    logic [NREG*8-1:0] exp;
    exp = regs;
    exp[20*8 +: 8] = 8'h11;
    exp[21*8 +: 8] = 8'h22;
    wr_hdr(8'd20, 8'd3, ok);
    send_byte(8'h11, a1);
    send_byte(8'h22, a2);
    send_byte(8'h33, a3);
    bus_stop();
    chk("R9", "acks across top", ok & a1 & a2 & a3, 1);
    chk("R9", "only 20 and 21 changed", (regs == exp), 1);
    wr_hdr(8'd200, 8'd1, ok);
    send_byte(8'h44, a1);
    bus_stop();
    chk("R9", "far write acked", ok & a1, 1);
    chk("R9", "far write dropped", (regs == exp), 1);
    rd_hdr(8'd21, ok);
    recv_byte(1'b1, b);
    recv_byte(1'b1, b); chk("R9", "reg21 read", b, 8'h22);
    recv_byte(1'b1, b); chk("R9", "index 22 reads zero", b, 8'h00);
    recv_byte(1'b0, b); chk("R9", "index 23 reads zero", b, 8'h00);
    bus_stop();
  endtask

  task automatic t_abort_stop();
    logic ok, a;
    wr_hdr(8'd12, 8'd3, ok);
    send_byte(8'h77, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    chk("R10", "completed byte kept", rg(12), 8'h77);
    chk("R10", "partial byte dropped", rg(13), 8'h00);
    wr_hdr(8'd13, 8'd1, ok);
    send_byte(8'h5A, a);
    bus_stop();
    chk("R10", "recovers after stop", {ok & a, rg(13)}, {1'b1, 8'h5A});
  endtask

  task automatic t_abort_start();
    logic ok, a0, a1, a2, a3;
    wr_hdr(8'd14, 8'd2, ok);
    send_byte(8'h3C, a0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_rstart();
    send_byte(8'hD2, a0);
    chk("R10", "address after mid-byte start", a0, 1);
    send_byte(8'd15, a1);
    send_byte(8'd1, a2);
    send_byte(8'h99, a3);
    bus_stop();
    chk("R10", "reg14 kept", rg(14), 8'h3C);
    chk("R10", "reg15 new transfer", rg(15), 8'h99);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tot++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_write_block();
    t_extra_bytes();
    t_bad_addr();
    t_read_block();
    t_ro_regs();
    t_count_reg();
    t_oob();
    t_abort_stop();
    t_abort_start();
    summary();
    $finish;
  end
endmodule